// File: doc/BRIEF.md
# CCD Line and Field Region Counter

This block tracks where the readout of an interline CCD currently stands. It counts pixel clocks across each line, including horizontal blanking. It also counts lines across each field of an interlaced 625-line frame. On every pixel clock it labels the current position with a 3-bit region code. From the same position it produces horizontal and vertical sync, a blanking flag, a field-parity flag and a clamp window over the rear optical-black columns. Downstream timing generators and video processing use these outputs to decide what to do with each sample. The block drives no sensor pins and produces no analog levels.

Each line starts with dummy register stages. After them come a short front optical-black margin, the effective pixels, a longer rear optical-black margin, and then blanking up to the end of the line period. The sensor uses field readout, so each field carries half of the frame's optical-black and effective rows. The two fields differ in length. The even field carries one extra vertical dummy line, placed ahead of its optical-black rows, and is therefore one line longer than the odd field.

All outputs come from one register stage. Each output reflects the counter position of the previous enabled clock. Holding the enable low freezes the counters and every output.

Top module: `ccd_region_timer`

## Requirements
- R1: While rst_n is low, region_o is 0, blank_o is 1, clamp_o is 0, field_o is 0, and both syncs are inactive. The syncs are inactive low when SYNC_ACTIVE_LOW is 0.
- R2: On an effective line, the region code depends on the pixel index p, counted from 0. For p below H_DUMMY the code is 1 (dummy). The next H_FOB pixels give 2 (front optical black). The next H_EFF pixels give 3 (effective). The next H_ROB pixels give 4 (rear optical black). All remaining pixels up to LINE_PIX-1 give 0 (blanking). With the defaults these are 0..21, 22..24, 25..776, 777..816 and 817..907.
- R3: The row class depends on the field line index. In the odd field (field_o 0), lines 0 to V_FOB-1 are front optical-black rows. The next V_EFF lines are effective rows. The next V_ROB lines are rear optical-black rows. The rest of the field is blank. In the even field (field_o 1), line 0 is a vertical dummy line, and the same sequence follows shifted down by one line.
- R4: On non-effective rows, a pixel in horizontal blanking or on a blank row gives code 0. A horizontal dummy pixel gives code 1. Every other pixel gives 2 on a front optical-black row, 4 on a rear optical-black row, and 1 on the vertical dummy line. Codes above 4 never appear.
- R5: The odd field lasts FRAME_LINES/2 lines (rounded down) and the even field lasts one line more. field_o is 0 in the odd field and 1 in the even field, and it alternates at every field boundary, starting with the odd field after reset.
- R6: hsync_o is active for pixel indices HS_START to HS_START+HS_W-1 of every line and inactive otherwise. Active means high when SYNC_ACTIVE_LOW is 0. The sync lies inside horizontal blanking.
- R7: vsync_o is active for field lines VS_START to VS_START+VS_W-1 in both fields, lying within blank rows.
- R8: blank_o is 1 exactly when the region code is 0.
- R9: clamp_o is 1 for pixels in the rear optical-black columns of every row that is not blank, including optical-black and dummy rows. It is 0 everywhere else.
- R10: Every output shows the classification of the position the counters held before the most recent enabled clock edge. After reset is released, the first enabled edge shows position line 0, pixel 0.
- R11: While en is low, the counters do not advance and all outputs keep their values. On resuming, counting continues from the held position.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Pixel clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| en | input | 1 | Count enable; low freezes the block |
| region_o | output | 3 | Region code: 0 blank, 1 dummy, 2 front OB, 3 effective, 4 rear OB |
| blank_o | output | 1 | High when the region code is blanking |
| hsync_o | output | 1 | Horizontal sync, polarity set by SYNC_ACTIVE_LOW |
| vsync_o | output | 1 | Vertical sync, polarity set by SYNC_ACTIVE_LOW |
| field_o | output | 1 | Field parity: 0 odd, 1 even |
| clamp_o | output | 1 | Clamp window over rear optical-black columns of live rows |

## Verification
The properties assume the parameter set passes the elaboration checks. In particular, the sync windows must fall inside the blank pixels and blank rows, and the frame length must be odd. The properties also assume reset is asserted before the first clock edge. en may take any pattern, since the hold property only compares consecutive outputs across a cycle in which en was low. The stimulus changes rst_n and en only on the falling clock edge. It keeps en high while walking the position table and drops it for a single contiguous window. It shortens the field through a vertical parameter override so that two full frames fit in the run without changing the horizontal layout.

// File: rtl/ccd_region_pkg.sv
package ccd_region_pkg;
   typedef enum logic [2:0] {
      RGN_BLANK = 3'd0,
      RGN_DUMMY = 3'd1,
      RGN_FOB   = 3'd2,
      RGN_EFF   = 3'd3,
      RGN_ROB   = 3'd4
   } rgn_e;
endpackage

// File: rtl/ccd_pos_counter.sv
module ccd_pos_counter #(
   parameter int LINE_PIX   = 908,
   parameter int ODD_LINES  = 312,
   parameter int EVEN_LINES = 313,
   parameter int PIX_W      = 10,
   parameter int LINE_W     = 9
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              en,
   output logic [PIX_W-1:0]  pix_o,
   output logic [LINE_W-1:0] line_o,
   output logic              field_o
);
   localparam logic [PIX_W-1:0]  PIX_LAST  = PIX_W'(LINE_PIX - 1);
   localparam logic [LINE_W-1:0] ODD_LAST  = LINE_W'(ODD_LINES - 1);
   localparam logic [LINE_W-1:0] EVEN_LAST = LINE_W'(EVEN_LINES - 1);

   logic pix_wrap;
   logic line_wrap;

   assign pix_wrap  = (pix_o == PIX_LAST);
   assign line_wrap = (line_o == (field_o ? EVEN_LAST : ODD_LAST));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         pix_o   <= '0;
         line_o  <= '0;
         field_o <= 1'b0;
      end else if (en) begin
         if (pix_wrap) begin
            pix_o <= '0;
            if (line_wrap) begin
               line_o  <= '0;
               field_o <= ~field_o;
            end else begin
               line_o <= line_o + 1'b1;
            end
         end else begin
            pix_o <= pix_o + 1'b1;
         end
      end
   end
endmodule

// File: rtl/ccd_col_decode.sv
module ccd_col_decode
   import ccd_region_pkg::*;
#(
   parameter int PIX_W    = 10,
   parameter int H_DUMMY  = 22,
   parameter int H_FOB    = 3,
   parameter int H_EFF    = 752,
   parameter int H_ROB    = 40,
   parameter int HS_START = 840,
   parameter int HS_W     = 64
) (
   input  logic [PIX_W-1:0] pix_i,
   output rgn_e             cls_o,
   output logic             hsync_o
);
   localparam int FOB_S = H_DUMMY;
   localparam int EFF_S = FOB_S + H_FOB;
   localparam int ROB_S = EFF_S + H_EFF;
   localparam int BLK_S = ROB_S + H_ROB;
   localparam int HS_E  = HS_START + HS_W;

   int p;
   assign p = int'(pix_i);

   always_comb begin
      if (p < FOB_S)      cls_o = RGN_DUMMY;
      else if (p < EFF_S) cls_o = RGN_FOB;
      else if (p < ROB_S) cls_o = RGN_EFF;
      else if (p < BLK_S) cls_o = RGN_ROB;
      else                cls_o = RGN_BLANK;
   end

   assign hsync_o = (p >= HS_START) && (p < HS_E);
endmodule

// File: rtl/ccd_row_decode.sv
module ccd_row_decode
   import ccd_region_pkg::*;
#(
   parameter int LINE_W   = 9,
   parameter int V_FOB    = 6,
   parameter int V_EFF    = 291,
   parameter int V_ROB    = 1,
   parameter int VS_START = 305,
   parameter int VS_W     = 3
) (
   input  logic [LINE_W-1:0] line_i,
   input  logic              field_i,
   output rgn_e              cls_o,
   output logic              vsync_o
);
   localparam int EFF_S = V_FOB;
   localparam int ROB_S = EFF_S + V_EFF;
   localparam int BLK_S = ROB_S + V_ROB;
   localparam int VS_E  = VS_START + VS_W;

   int l;
   int r;
   assign l = int'(line_i);
   assign r = field_i ? (l - 1) : l;

   always_comb begin
      if (field_i && (l == 0)) cls_o = RGN_DUMMY;
      else if (r < EFF_S)      cls_o = RGN_FOB;
      else if (r < ROB_S)      cls_o = RGN_EFF;
      else if (r < BLK_S)      cls_o = RGN_ROB;
      else                     cls_o = RGN_BLANK;
   end

   assign vsync_o = (l >= VS_START) && (l < VS_E);
endmodule

// File: rtl/ccd_region_timer.sv
module ccd_region_timer
   import ccd_region_pkg::*;
#(
   parameter int LINE_PIX        = 908,
   parameter int H_DUMMY         = 22,
   parameter int H_FOB           = 3,
   parameter int H_EFF           = 752,
   parameter int H_ROB           = 40,
   parameter int HS_START        = 840,
   parameter int HS_W            = 64,
   parameter int FRAME_LINES     = 625,
   parameter int V_FOB           = 6,
   parameter int V_EFF           = 291,
   parameter int V_ROB           = 1,
   parameter int VS_START        = 305,
   parameter int VS_W            = 3,
   parameter bit SYNC_ACTIVE_LOW = 1'b0
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       en,
   output logic [2:0] region_o,
   output logic       blank_o,
   output logic       hsync_o,
   output logic       vsync_o,
   output logic       field_o,
   output logic       clamp_o
);
   localparam int ODD_LINES  = FRAME_LINES / 2;
   localparam int EVEN_LINES = FRAME_LINES - ODD_LINES;
   localparam int H_ACTIVE   = H_DUMMY + H_FOB + H_EFF + H_ROB;
   localparam int V_ACTIVE   = 1 + V_FOB + V_EFF + V_ROB;
   localparam int PIX_W      = $clog2(LINE_PIX);
   localparam int LINE_W     = $clog2(EVEN_LINES);

   if (H_ACTIVE >= LINE_PIX) begin : g_bad_hlen
      $error("line period leaves no horizontal blanking");
   end
   if ((HS_START < H_ACTIVE) || (HS_START + HS_W > LINE_PIX) || (HS_W < 1)) begin : g_bad_hs
      $error("horizontal sync window must lie inside blanking");
   end
   if ((FRAME_LINES % 2) != 1) begin : g_bad_frame
      $error("frame length must be odd for unequal interlaced fields");
   end
   if ((VS_START < V_ACTIVE) || (VS_START + VS_W > ODD_LINES) || (VS_W < 1)) begin : g_bad_vs
      $error("vertical sync window must lie inside blank rows of both fields");
   end

   logic [PIX_W-1:0]  pix;
   logic [LINE_W-1:0] line;
   logic              field;
   rgn_e              hcls;
   rgn_e              vcls;
   logic              hs_raw;
   logic              vs_raw;
   rgn_e              rgn_d;
   logic              blank_d;
   logic              clamp_d;
   logic              hs_d;
   logic              vs_d;

   ccd_pos_counter #(
      .LINE_PIX(LINE_PIX), .ODD_LINES(ODD_LINES), .EVEN_LINES(EVEN_LINES),
      .PIX_W(PIX_W), .LINE_W(LINE_W)
   ) u_cnt (
      .clk(clk), .rst_n(rst_n), .en(en),
      .pix_o(pix), .line_o(line), .field_o(field)
   );

   ccd_col_decode #(
      .PIX_W(PIX_W), .H_DUMMY(H_DUMMY), .H_FOB(H_FOB), .H_EFF(H_EFF),
      .H_ROB(H_ROB), .HS_START(HS_START), .HS_W(HS_W)
   ) u_col (
      .pix_i(pix), .cls_o(hcls), .hsync_o(hs_raw)
   );

   ccd_row_decode #(
      .LINE_W(LINE_W), .V_FOB(V_FOB), .V_EFF(V_EFF), .V_ROB(V_ROB),
      .VS_START(VS_START), .VS_W(VS_W)
   ) u_row (
      .line_i(line), .field_i(field), .cls_o(vcls), .vsync_o(vs_raw)
   );

   always_comb begin
      if ((hcls == RGN_BLANK) || (vcls == RGN_BLANK))      rgn_d = RGN_BLANK;
      else if ((hcls == RGN_DUMMY) || (vcls == RGN_DUMMY)) rgn_d = RGN_DUMMY;
      else if (vcls == RGN_EFF)                            rgn_d = hcls;
      else                                                 rgn_d = vcls;
   end

   assign blank_d = (hcls == RGN_BLANK) || (vcls == RGN_BLANK);
   assign clamp_d = (hcls == RGN_ROB) && (vcls != RGN_BLANK);

   if (SYNC_ACTIVE_LOW) begin : g_sync_low
      assign hs_d = ~hs_raw;
      assign vs_d = ~vs_raw;
   end else begin : g_sync_high
      assign hs_d = hs_raw;
      assign vs_d = vs_raw;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         region_o <= RGN_BLANK;
         blank_o  <= 1'b1;
         clamp_o  <= 1'b0;
         hsync_o  <= SYNC_ACTIVE_LOW;
         vsync_o  <= SYNC_ACTIVE_LOW;
         field_o  <= 1'b0;
      end else if (en) begin
         region_o <= rgn_d;
         blank_o  <= blank_d;
         clamp_o  <= clamp_d;
         hsync_o  <= hs_d;
         vsync_o  <= vs_d;
         field_o  <= field;
      end
   end
endmodule

// File: rtl/ccd_region_timer_chk.sv
module ccd_region_timer_chk #(
   parameter bit SYNC_ACTIVE_LOW = 1'b0
) (
   input logic       clk,
   input logic       rst_n,
   input logic       en,
   input logic [2:0] region_o,
   input logic       blank_o,
   input logic       hsync_o,
   input logic       vsync_o,
   input logic       field_o,
   input logic       clamp_o
);
   logic hs_act;
   logic vs_act;
   assign hs_act = SYNC_ACTIVE_LOW ? ~hsync_o : hsync_o;
   assign vs_act = SYNC_ACTIVE_LOW ? ~vsync_o : vsync_o;

   AST_REGION_CODE: assert property (@(posedge clk) disable iff (!rst_n)
      region_o <= 3'd4); // R4
   AST_BLANK_CODE: assert property (@(posedge clk) disable iff (!rst_n)
      blank_o == (region_o == 3'd0)); // R8
   AST_CLAMP_LIVE: assert property (@(posedge clk) disable iff (!rst_n)
      clamp_o |-> !blank_o); // R9
   AST_HSYNC_IN_BLANK: assert property (@(posedge clk) disable iff (!rst_n)
      hs_act |-> blank_o); // R6
   AST_VSYNC_IN_BLANK: assert property (@(posedge clk) disable iff (!rst_n)
      vs_act |-> blank_o); // R7
   AST_FIELD_EDGE: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(rst_n) && (field_o != $past(field_o))) |-> (region_o == 3'd1)); // R5
   AST_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(rst_n) && !$past(en)) |-> ($stable(region_o) && $stable(field_o)
         && $stable(hsync_o) && $stable(vsync_o) && $stable(clamp_o))); // R11
endmodule

bind ccd_region_timer ccd_region_timer_chk #(.SYNC_ACTIVE_LOW(SYNC_ACTIVE_LOW)) u_chk (
   .clk(clk), .rst_n(rst_n), .en(en), .region_o(region_o), .blank_o(blank_o),
   .hsync_o(hsync_o), .vsync_o(vsync_o), .field_o(field_o), .clamp_o(clamp_o)
);

// File: tb/ccd_region_timer_bench.sv
module ccd_region_timer_bench;
   localparam int CLK_PERIOD = 10;
   localparam int LP         = 908;
   localparam int ODD_L      = 12;
   localparam int FRAME_L    = 25;
   localparam int NV         = 33;

   // {field, line[15:0], pix[15:0], region[2:0], clamp, hsync, vsync}
   localparam logic [38:0] TBL [NV] = '{
      {1'b0, 16'd0,  16'd0,   3'd1, 1'b0, 1'b0, 1'b0},
      {1'b0, 16'd0,  16'd22,  3'd2, 1'b0, 1'b0, 1'b0},
      {1'b0, 16'd0,  16'd500, 3'd2, 1'b0, 1'b0, 1'b0},
      {1'b0, 16'd0,  16'd777, 3'd2, 1'b1, 1'b0, 1'b0},
      {1'b0, 16'd0,  16'd850, 3'd0, 1'b0, 1'b1, 1'b0},
      {1'b0, 16'd2,  16'd21,  3'd1, 1'b0, 1'b0, 1'b0},
      {1'b0, 16'd2,  16'd24,  3'd2, 1'b0, 1'b0, 1'b0},
      {1'b0, 16'd2,  16'd25,  3'd3, 1'b0, 1'b0, 1'b0},
      {1'b0, 16'd2,  16'd776, 3'd3, 1'b0, 1'b0, 1'b0},
      {1'b0, 16'd2,  16'd777, 3'd4, 1'b1, 1'b0, 1'b0},
      {1'b0, 16'd2,  16'd816, 3'd4, 1'b1, 1'b0, 1'b0},
      {1'b0, 16'd2,  16'd817, 3'd0, 1'b0, 1'b0, 1'b0},
      {1'b0, 16'd2,  16'd839, 3'd0, 1'b0, 1'b0, 1'b0},
      {1'b0, 16'd2,  16'd840, 3'd0, 1'b0, 1'b1, 1'b0},
      {1'b0, 16'd2,  16'd903, 3'd0, 1'b0, 1'b1, 1'b0},
      {1'b0, 16'd2,  16'd904, 3'd0, 1'b0, 1'b0, 1'b0},
      {1'b0, 16'd6,  16'd500, 3'd3, 1'b0, 1'b0, 1'b0},
      {1'b0, 16'd7,  16'd500, 3'd4, 1'b0, 1'b0, 1'b0},
      {1'b0, 16'd7,  16'd800, 3'd4, 1'b1, 1'b0, 1'b0},
      {1'b0, 16'd8,  16'd500, 3'd0, 1'b0, 1'b0, 1'b0},
      {1'b0, 16'd8,  16'd800, 3'd0, 1'b0, 1'b0, 1'b0},
      {1'b0, 16'd10, 16'd0,   3'd0, 1'b0, 1'b0, 1'b1},
      {1'b0, 16'd11, 16'd907, 3'd0, 1'b0, 1'b0, 1'b0},
      {1'b1, 16'd0,  16'd0,   3'd1, 1'b0, 1'b0, 1'b0},
      {1'b1, 16'd0,  16'd500, 3'd1, 1'b0, 1'b0, 1'b0},
      {1'b1, 16'd0,  16'd800, 3'd1, 1'b1, 1'b0, 1'b0},
      {1'b1, 16'd1,  16'd500, 3'd2, 1'b0, 1'b0, 1'b0},
      {1'b1, 16'd3,  16'd500, 3'd3, 1'b0, 1'b0, 1'b0},
      {1'b1, 16'd7,  16'd500, 3'd3, 1'b0, 1'b0, 1'b0},
      {1'b1, 16'd8,  16'd500, 3'd4, 1'b0, 1'b0, 1'b0},
      {1'b1, 16'd9,  16'd500, 3'd0, 1'b0, 1'b0, 1'b0},
      {1'b1, 16'd10, 16'd500, 3'd0, 1'b0, 1'b0, 1'b1},
      {1'b1, 16'd12, 16'd907, 3'd0, 1'b0, 1'b0, 1'b0}
   };

   logic       clk = 1'b0;
   logic       rst_n;
   logic       en;
   logic [2:0] region_o;
   logic       blank_o;
   logic       hsync_o;
   logic       vsync_o;
   logic       field_o;
   logic       clamp_o;

   int  n_chk  = 0;
   int  n_fail = 0;
   int  cyc    = 0;
   bit  done   = 1'b0;

   always #(CLK_PERIOD / 2) clk = ~clk;

   always @(posedge clk or negedge rst_n) begin
      if (!rst_n)  cyc <= 0;
      else if (en) cyc <= cyc + 1;
   end

   ccd_region_timer #(
      .FRAME_LINES(FRAME_L), .V_FOB(2), .V_EFF(5), .V_ROB(1),
      .VS_START(10), .VS_W(1)
   ) u_ccd_region_timer (
      .clk(clk), .rst_n(rst_n), .en(en), .region_o(region_o),
      .blank_o(blank_o), .hsync_o(hsync_o), .vsync_o(vsync_o),
      .field_o(field_o), .clamp_o(clamp_o)
   );

   task automatic chk(input string req, input int act, input int exp);
      n_chk++;
      if (act != exp) begin
         n_fail++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   task automatic reset_state(input string req);
      chk({req, " region"}, int'(region_o), 0);
      chk({req, " blank"},  int'(blank_o), 1);
      chk({req, " clamp"},  int'(clamp_o), 0);
      chk({req, " hsync"},  int'(hsync_o), 0);
      chk({req, " vsync"},  int'(vsync_o), 0);
      chk({req, " field"},  int'(field_o), 0);
   endtask

   task automatic wait_pos(input int idx);
      while (cyc < idx + 1) @(negedge clk);
   endtask

   initial begin
      #(CLK_PERIOD * 100000);
      if (!done) begin
         n_chk++;
         n_fail++;
         $display("FAIL R10 watchdog actual=running expected=finished");
         $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
         $finish;
      end
   end

   initial begin
      logic [2:0] s_rgn;
      logic       s_cl, s_hs, s_vs, s_fd;
      rst_n = 1'b0;
      en    = 1'b0;
      repeat (3) @(negedge clk);
      reset_state("R1");
      rst_n = 1'b1;
      en    = 1'b1;
      #1;
      chk("R10 no edge yet region", int'(region_o), 0);

      // table walk: region codes, clamp, syncs, blank, field
      for (int i = 0; i < NV; i++) begin
         logic [38:0] e;
         int idx;
         e   = TBL[i];
         idx = (e[38] ? ODD_L * LP : 0) + int'(e[37:22]) * LP + int'(e[21:6]);
         wait_pos(idx);
         chk($sformatf("R2 R3 R4 R10 region f%0d l%0d p%0d", e[38], e[37:22], e[21:6]),
             int'(region_o), int'(e[5:3]));
         chk($sformatf("R9 clamp l%0d p%0d", e[37:22], e[21:6]), int'(clamp_o), int'(e[2]));
         chk($sformatf("R6 hsync p%0d", e[21:6]), int'(hsync_o), int'(e[1]));
         chk($sformatf("R7 vsync l%0d", e[37:22]), int'(vsync_o), int'(e[0]));
         chk("R8 blank", int'(blank_o), int'(e[5:3] == 3'd0));
         chk("R5 field", int'(field_o), int'(e[38]));
      end

      // R11: hold with enable low
      en    = 1'b0;
      s_rgn = region_o; s_cl = clamp_o; s_hs = hsync_o; s_vs = vsync_o; s_fd = field_o;
      repeat (20) @(negedge clk);
      chk("R11 hold region", int'(region_o), int'(s_rgn));
      chk("R11 hold clamp",  int'(clamp_o), int'(s_cl));
      chk("R11 hold hsync",  int'(hsync_o), int'(s_hs));
      chk("R11 hold vsync",  int'(vsync_o), int'(s_vs));
      chk("R11 hold field",  int'(field_o), int'(s_fd));
      en = 1'b1;

      // R5: wrap to next frame, odd field again; also proves R11 resumed in place
      wait_pos(FRAME_L * LP);
      chk("R5 frame wrap field", int'(field_o), 0);
      chk("R11 R3 frame wrap region", int'(region_o), 1);
      wait_pos(FRAME_L * LP + 2 * LP + 25);
      chk("R11 resumed effective", int'(region_o), 3);

      // mid-run reset
      rst_n = 1'b0;
      #1;
      reset_state("R1 midrun");
      @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      chk("R10 first edge region", int'(region_o), 1);
      chk("R10 first edge field", int'(field_o), 0);
      wait_pos(25);
      chk("R2 first effective pixel after reset", int'(region_o), 2);

      done = 1'b1;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end
endmodule